// File: doc/BRIEF.md
# Power-Save Wakeup Cause Controller

This controller sits in the exception unit of a 64-bit core. It handles the low-power instructions and the wakeup that follows them. When any of the four power-save instructions (doze, nap, sleep, winkle) retires, the controller halts the core and raises an internal power-save flag. It also issues a one-cycle MSR write that turns on the external-interrupt enable bit, so that an interrupt can still wake the core.

While the flag is set, the next exception request is treated as a wakeup. A machine check keeps its own type and vector. Every other supported cause is redirected to the system-reset vector, and a 4-bit cause code is returned for the exception unit to OR into the saved machine-state word. A cause that cannot wake the core raises an abort pulse instead of an exception. Exceptions taken outside power-save pass straight through, with no saved-state bits.

Top module: `pm_wake_ctrl`

## Requirements
- R1: A retiring power-save instruction sets `halted` from the next cycle, when no exception is requested in the same cycle. `pmInsn` is one-hot: bit 0 doze, bit 1 nap, bit 2 sleep, bit 3 winkle.
- R2: One cycle after power-save entry, `msrWe` pulses for one cycle and `msrWrData` equals `msrIn` with bit 15 (external-interrupt enable) set.
- R3: `halted` drops in the same cycle the wakeup exception is requested, and it stays low after that.
- R4: Every delivered wakeup has bit 16 of `srr1Or` set, whichever of the four instructions was used.
- R5: A machine check (type 1) during power-save is delivered as type 1 at vector 0x200, with `srr1Or` holding only bit 16.
- R6: The wakeup causes reset (0), external (2), decrementer (3), doorbell (4), hypervisor doorbell (5) and hypervisor maintenance (6) are delivered as type 0 at vector 0x100.
- R7: On a redirected wakeup, `srr1Or[21:18]` carries the cause code: reset 0x4, external 0x8, decrementer 0x6, doorbell 0x5, hypervisor doorbell 0x3, hypervisor maintenance 0xA.
- R8: Any other type arriving during power-save gives a one-cycle `abort` pulse, no `excOutValid`, and clears power-save.
- R9: Outside power-save, the exception passes through unchanged, with `srr1Or` = 0. The vectors are: 0→0x100, 1→0x200, 2→0x500, 3→0x900, 4→0xA00, 5→0xE80, 6→0xEA0, 7→0x700, 8→0xC00, any other type→0x000.
- R10: When a power-save instruction and an exception arrive in the same cycle, only the exception is served. Power-save is not entered and `msrWe` stays low.
- R11: During reset, `halted`, `excOutValid`, `abort` and `msrWe` are 0, and reset clears power-save.
- R12: Outputs are registered. `excOutValid` or `abort` is high for exactly one cycle, on the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pmInsn | input | 4 | One-hot retiring power-save instruction |
| excReq | input | 1 | Exception request strobe |
| excType | input | 4 | Requested exception type |
| msrIn | input | XLEN | Current machine-state word |
| halted | output | 1 | Core halted in power-save |
| excOutValid | output | 1 | Delivered exception strobe |
| excOutType | output | 4 | Delivered exception type |
| excOutVector | output | XLEN | Delivered exception vector |
| srr1Or | output | XLEN | Bits to OR into the saved machine state |
| abort | output | 1 | Unsupported wakeup cause |
| msrWe | output | 1 | MSR write strobe on power-save entry |
| msrWrData | output | XLEN | MSR value with interrupt enable forced |

## Verification
The hardest case is the collision of an instruction and an exception in the same cycle. A close second is an unsupported cause arriving while the core is halted. The stimulus reaches both by first entering power-save with each of the four one-hot instruction codes in turn, and then aiming a single exception of a chosen type at the halted core. For the collision, the bench drives the instruction and the request on the same edge and then checks that `msrWe` stays low and `halted` never rises.

// File: rtl/pm_wake_pkg.sv
package pm_wake_pkg;

  localparam int EXC_W   = 4;
  localparam int CAUSE_W = 4;

  localparam logic [EXC_W-1:0] EXC_RESET    = 4'd0;
  localparam logic [EXC_W-1:0] EXC_MCHECK   = 4'd1;
  localparam logic [EXC_W-1:0] EXC_EXTERNAL = 4'd2;
  localparam logic [EXC_W-1:0] EXC_DECR     = 4'd3;
  localparam logic [EXC_W-1:0] EXC_DBELL    = 4'd4;
  localparam logic [EXC_W-1:0] EXC_HDBELL   = 4'd5;
  localparam logic [EXC_W-1:0] EXC_HMAINT   = 4'd6;
  localparam logic [EXC_W-1:0] EXC_PROGRAM  = 4'd7;
  localparam logic [EXC_W-1:0] EXC_SYSCALL  = 4'd8;

  // Strobes from control to datapath, valid in the request cycle
  typedef struct packed {
    logic take;      // an exception is delivered
    logic wake;      // delivered exception ends power-save
    logic redirect;  // delivered as system reset with a cause code
    logic abortNow;  // unsupported cause during power-save
    logic enterPs;   // power-save entry accepted
  } ctrlStrobes_t;

  function automatic logic isWakeCause(input logic [EXC_W-1:0] t);
    return (t == EXC_RESET) || (t == EXC_EXTERNAL) || (t == EXC_DECR) ||
           (t == EXC_DBELL) || (t == EXC_HDBELL) || (t == EXC_HMAINT);
  endfunction

  function automatic logic [CAUSE_W-1:0] causeCode(input logic [EXC_W-1:0] t);
    case (t)
      EXC_RESET:    return 4'h4;
      EXC_EXTERNAL: return 4'h8;
      EXC_DECR:     return 4'h6;
      EXC_DBELL:    return 4'h5;
      EXC_HDBELL:   return 4'h3;
      EXC_HMAINT:   return 4'hA;
      default:      return 4'h0;
    endcase
  endfunction

  function automatic logic [15:0] vectorOffset(input logic [EXC_W-1:0] t);
    case (t)
      EXC_RESET:    return 16'h0100;
      EXC_MCHECK:   return 16'h0200;
      EXC_EXTERNAL: return 16'h0500;
      EXC_DECR:     return 16'h0900;
      EXC_DBELL:    return 16'h0A00;
      EXC_HDBELL:   return 16'h0E80;
      EXC_HMAINT:   return 16'h0EA0;
      EXC_PROGRAM:  return 16'h0700;
      EXC_SYSCALL:  return 16'h0C00;
      default:      return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/pm_wake_ctl.sv
module pm_wake_ctl
  import pm_wake_pkg::*;
#(
  parameter int PM_KINDS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [PM_KINDS-1:0] pmInsn,
  input  logic                excReq,
  input  logic [EXC_W-1:0]    excType,
  output logic                psFlag,
  output logic                halted,
  output ctrlStrobes_t        ctrl
);

  logic anyPmInsn;
  logic isMcheck;
  logic supported;
  logic wakeReq;

  always_comb begin
    anyPmInsn = |pmInsn;
    isMcheck  = (excType == EXC_MCHECK);
    supported = isMcheck | isWakeCause(excType);
    wakeReq   = excReq & psFlag;

    ctrl.take     = excReq & (~psFlag | supported);
    ctrl.wake     = wakeReq & supported;
    ctrl.redirect = wakeReq & supported & ~isMcheck;
    ctrl.abortNow = wakeReq & ~supported;
    // an exception in the same cycle wins over entry
    ctrl.enterPs  = anyPmInsn & ~excReq & ~psFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             psFlag <= 1'b0;
    else if (excReq)       psFlag <= 1'b0;
    else if (ctrl.enterPs) psFlag <= 1'b1;
  end

  // drops in the very cycle the waking request is presented
  assign halted = psFlag & ~excReq;

endmodule

// File: rtl/pm_wake_dp.sv
module pm_wake_dp
  import pm_wake_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int EE_BIT    = 15,
  parameter int DOZE_BIT  = 16,
  parameter int CAUSE_LSB = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     ctrl,
  input  logic [EXC_W-1:0] excType,
  input  logic [XLEN-1:0]  msrIn,
  output logic             excOutValid,
  output logic [EXC_W-1:0] excOutType,
  output logic [XLEN-1:0]  excOutVector,
  output logic [XLEN-1:0]  srr1Or,
  output logic             abort,
  output logic             msrWe,
  output logic [XLEN-1:0]  msrWrData
);

  localparam logic [XLEN-1:0] EE_MASK = XLEN'(1) << EE_BIT;

  logic [EXC_W-1:0] typeNext;
  logic [XLEN-1:0]  vecNext;
  logic [XLEN-1:0]  srr1Next;

  always_comb begin
    typeNext = ctrl.redirect ? EXC_RESET : excType;
    vecNext  = XLEN'(vectorOffset(typeNext));
    srr1Next = '0;
    if (ctrl.wake) begin
      srr1Next[DOZE_BIT] = 1'b1;
      if (ctrl.redirect) srr1Next[CAUSE_LSB +: CAUSE_W] = causeCode(excType);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      excOutValid  <= 1'b0;
      excOutType   <= '0;
      excOutVector <= '0;
      srr1Or       <= '0;
      abort        <= 1'b0;
      msrWe        <= 1'b0;
      msrWrData    <= '0;
    end else begin
      excOutValid  <= ctrl.take;
      excOutType   <= ctrl.take ? typeNext : '0;
      excOutVector <= ctrl.take ? vecNext : '0;
      srr1Or       <= ctrl.take ? srr1Next : '0;
      abort        <= ctrl.abortNow;
      msrWe        <= ctrl.enterPs;
      msrWrData    <= ctrl.enterPs ? (msrIn | EE_MASK) : '0;
    end
  end

endmodule

// File: rtl/pm_wake_ctrl.sv
module pm_wake_ctrl
  import pm_wake_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int EE_BIT    = 15,
  parameter int DOZE_BIT  = 16,
  parameter int CAUSE_LSB = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       pmInsn,
  input  logic             excReq,
  input  logic [3:0]       excType,
  input  logic [XLEN-1:0]  msrIn,
  output logic             halted,
  output logic             excOutValid,
  output logic [3:0]       excOutType,
  output logic [XLEN-1:0]  excOutVector,
  output logic [XLEN-1:0]  srr1Or,
  output logic             abort,
  output logic             msrWe,
  output logic [XLEN-1:0]  msrWrData
);

  ctrlStrobes_t ctrl;
  logic         psFlag;

  pm_wake_ctl #(.PM_KINDS(4)) uCtl (
    .clk(clk), .rstN(rstN), .pmInsn(pmInsn), .excReq(excReq),
    .excType(excType), .psFlag(psFlag), .halted(halted), .ctrl(ctrl)
  );

  pm_wake_dp #(
    .XLEN(XLEN), .EE_BIT(EE_BIT), .DOZE_BIT(DOZE_BIT), .CAUSE_LSB(CAUSE_LSB)
  ) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .excType(excType), .msrIn(msrIn),
    .excOutValid(excOutValid), .excOutType(excOutType),
    .excOutVector(excOutVector), .srr1Or(srr1Or), .abort(abort),
    .msrWe(msrWe), .msrWrData(msrWrData)
  );

endmodule

// File: rtl/pm_wake_chk.sv
module pm_wake_chk
  import pm_wake_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int EE_BIT    = 15,
  parameter int DOZE_BIT  = 16,
  parameter int CAUSE_LSB = 18
) (
  input logic            clk,
  input logic            rstN,
  input logic [3:0]      pmInsn,
  input logic            excReq,
  input logic [3:0]      excType,
  input logic [XLEN-1:0] msrIn,
  input logic            psFlag,
  input logic            halted,
  input logic            excOutValid,
  input logic [3:0]      excOutType,
  input logic [XLEN-1:0] excOutVector,
  input logic [XLEN-1:0] srr1Or,
  input logic            abort,
  input logic            msrWe,
  input logic [XLEN-1:0] msrWrData
);

  assert_entry_halts_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((|pmInsn) && !excReq && !psFlag) |=> psFlag);

  assert_ee_forced_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|pmInsn) && !excReq && !psFlag) |=> (msrWe && msrWrData[EE_BIT] &&
      msrWrData == ($past(msrIn) | (XLEN'(1) << EE_BIT))));

  assert_wake_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (psFlag && excReq) |=> !psFlag);

  assert_doze_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (psFlag && excReq && (isWakeCause(excType) || excType == EXC_MCHECK))
      |=> (excOutValid && srr1Or[DOZE_BIT]));

  assert_redirect_R6: assert property (@(posedge clk) disable iff (!rstN)
    (psFlag && excReq && isWakeCause(excType))
      |=> (excOutType == EXC_RESET && excOutVector == XLEN'(16'h0100)));

  assert_unsupported_R8: assert property (@(posedge clk) disable iff (!rstN)
    (psFlag && excReq && !isWakeCause(excType) && excType != EXC_MCHECK)
      |=> (abort && !excOutValid));

  assert_passthru_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!psFlag && excReq) |=> (excOutValid && srr1Or == '0 &&
      excOutType == $past(excType)));

  assert_collision_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((|pmInsn) && excReq) |=> (!msrWe && !psFlag));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(excOutValid && abort));

  assert_halt_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> !halted);

endmodule

bind pm_wake_ctrl pm_wake_chk #(
  .XLEN(XLEN), .EE_BIT(EE_BIT), .DOZE_BIT(DOZE_BIT), .CAUSE_LSB(CAUSE_LSB)
) uChk (
  .clk(clk), .rstN(rstN), .pmInsn(pmInsn), .excReq(excReq), .excType(excType),
  .msrIn(msrIn), .psFlag(psFlag), .halted(halted), .excOutValid(excOutValid),
  .excOutType(excOutType), .excOutVector(excOutVector), .srr1Or(srr1Or),
  .abort(abort), .msrWe(msrWe), .msrWrData(msrWrData)
);

// File: tb/sim_pm_wake_ctrl.sv
`timescale 1ns/1ps
module sim_pm_wake_ctrl;

  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [3:0]      pmInsn = '0;
  logic            excReq = 1'b0;
  logic [3:0]      excType = '0;
  logic [XLEN-1:0] msrIn = 64'h9000_0000_0000_1033;
  logic            halted, excOutValid, abort, msrWe;
  logic [3:0]      excOutType;
  logic [XLEN-1:0] excOutVector, srr1Or, msrWrData;

  int errors = 0;
  int checks = 0;
  bit inPs = 1'b0;

  typedef struct {
    bit              isAbort;
    logic [3:0]      typ;
    logic [XLEN-1:0] vec;
    logic [XLEN-1:0] srr1;
    string           req;
  } expItem_t;

  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz

  pm_wake_ctrl #(.XLEN(XLEN)) u0 (
    .clk(clk), .rstN(rstN), .pmInsn(pmInsn), .excReq(excReq),
    .excType(excType), .msrIn(msrIn), .halted(halted),
    .excOutValid(excOutValid), .excOutType(excOutType),
    .excOutVector(excOutVector), .srr1Or(srr1Or), .abort(abort),
    .msrWe(msrWe), .msrWrData(msrWrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [XLEN-1:0] vecOf(input logic [3:0] t);
    case (t)
      4'd0: return 64'h100;  4'd1: return 64'h200;  4'd2: return 64'h500;
      4'd3: return 64'h900;  4'd4: return 64'hA00;  4'd5: return 64'hE80;
      4'd6: return 64'hEA0;  4'd7: return 64'h700;  4'd8: return 64'hC00;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [3:0] codeOf(input logic [3:0] t);
    case (t)
      4'd0: return 4'h4; 4'd2: return 4'h8; 4'd3: return 4'h6;
      4'd4: return 4'h5; 4'd5: return 4'h3; 4'd6: return 4'hA;
      default: return 4'hF;  // marks unsupported
    endcase
  endfunction

  function automatic expItem_t model(input logic [3:0] t, input bit ps);
    expItem_t e;
    e.isAbort = 1'b0; e.typ = t; e.vec = vecOf(t); e.srr1 = '0; e.req = "R9";
    if (ps) begin
      if (t == 4'd1) begin
        e.srr1 = 64'h1 << 16; e.req = "R5";
      end else if (codeOf(t) != 4'hF) begin
        e.typ = 4'd0; e.vec = 64'h100;
        e.srr1 = (64'h1 << 16) | (64'(codeOf(t)) << 18); e.req = "R6/R7";
      end else begin
        e.isAbort = 1'b1; e.typ = '0; e.vec = '0; e.req = "R8";
      end
    end
    return e;
  endfunction

  // monitor: compares each delivered result against the scoreboard
  always @(posedge clk) begin
    #2;
    if (rstN && (excOutValid || abort)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R12", "unexpected output", {excOutValid, abort}, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(abort == e.isAbort && excOutValid == !e.isAbort, e.req,
              "valid/abort", {excOutValid, abort}, {!e.isAbort, e.isAbort});
        if (!e.isAbort) begin
          check(excOutType == e.typ, e.req, "type", excOutType, e.typ);
          check(excOutVector == e.vec, e.req, "vector", excOutVector, e.vec);
          check(srr1Or == e.srr1, e.req, "srr1 bits", srr1Or, e.srr1);
        end else begin
          check(srr1Or == '0, "R8", "srr1 on abort", srr1Or, 0);
        end
      end
    end
  end

  task automatic sendExc(input logic [3:0] t);
    @(negedge clk);
    excReq = 1'b1; excType = t;
    expQ.push_back(model(t, inPs));
    #1 check(halted == 1'b0, "R3", "halted during wake request", halted, 0);
    inPs = 1'b0;
    @(negedge clk);
    excReq = 1'b0;
    check(halted == 1'b0, "R3", "halted after exception", halted, 0);
  endtask

  task automatic enterPs(input int k);
    @(negedge clk);
    pmInsn = 4'(1 << k);
    @(posedge clk); #2;
    check(halted == 1'b1, "R1", "halted after entry", halted, 1);
    check(msrWe == 1'b1, "R2", "msrWe pulse", msrWe, 1);
    check(msrWrData == (msrIn | 64'h8000), "R2", "msr EE forced",
          msrWrData, msrIn | 64'h8000);
    @(negedge clk);
    pmInsn = '0;
    inPs = 1'b1;
    @(posedge clk); #2;
    check(msrWe == 1'b0, "R2", "msrWe single pulse", msrWe, 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(halted == 0 && excOutValid == 0 && abort == 0 && msrWe == 0, "R11",
          "reset outputs", {halted, excOutValid, abort, msrWe}, 0);
    rstN = 1'b1;

    // R9 pass-through, outside power-save
    for (int t = 0; t <= 8; t++) sendExc(4'(t));
    sendExc(4'd12);

    // R4 R6 R7: each instruction kind, each wake cause
    for (int i = 0; i < 6; i++) begin
      logic [3:0] causes [6] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6};
      msrIn = 64'h9000_0000_0000_1033 ^ (64'(i) << 40);
      enterPs(i % 4);
      repeat (2) @(negedge clk);
      check(halted == 1'b1, "R1", "halted held while idle", halted, 1);
      sendExc(causes[i]);
    end

    // R5 machine check
    enterPs(1);
    sendExc(4'd1);
    // R8 unsupported causes
    enterPs(2);
    sendExc(4'd7);
    enterPs(3);
    sendExc(4'd12);
    // after abort the core is out of power-save: pass-through again (R8/R9)
    sendExc(4'd2);

    // R10 collision
    @(negedge clk);
    pmInsn = 4'b0100; excReq = 1'b1; excType = 4'd3;
    expQ.push_back(model(4'd3, 1'b0));
    @(posedge clk); #2;
    check(msrWe == 1'b0, "R10", "no entry on collision", msrWe, 0);
    @(negedge clk);
    pmInsn = '0; excReq = 1'b0;
    check(halted == 1'b0, "R10", "not halted after collision", halted, 0);

    // R11 reset while halted
    enterPs(0);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(halted == 1'b0, "R11", "reset clears halted", halted, 0);
    rstN = 1'b1; inPs = 1'b0;
    sendExc(4'd2);  // must pass through unchanged

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R12", "outstanding expected results",
          expQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule